// File: doc/BRIEF.md
# Programmer Host Command Interpreter

This block sits between a host byte link and the serial-programming engine of an in-system device programmer. Bytes from the host arrive on a valid/ready receive stream. Reply bytes leave on a valid/ready transmit stream. Each command is one ASCII letter, and some letters are followed by argument bytes. The interpreter holds the selected target code and a 16-bit address. Identification replies come from constants inside the block.

Operations on the target (enter, leave, memory reads and writes, erase, lock, signature read) go to an external sequencer. Each one is a request/done handshake carrying an operation code, the address and the data byte. A read returns its byte on done. Memory commands are refused until a supported target code has been selected. An acknowledged command replies 0x0D and a refused or unknown command replies '?' (0x3F).

Top module: `prog_cmd_interp`

## Requirements
- R1: After reset, rx_ready_o is 1, tx_valid_o and seq_req_o are 0, and the stored target code (seq_dev_o) is 0x00, which is not a supported code.
- R2: A 0x1B byte received while waiting for a command produces no reply and no request, and the next byte is decoded as a command.
- R3: 'T' consumes one byte, stores it as the target code and replies 0x0D. It is accepted whatever code is currently stored.
- R4: 'V' replies 0x31 then 0x35. 'v' replies 0x31 then 0x30.
- R5: 't' replies 0x12, 0x13, 0x38, 0x86, 0x00 in that order.
- R6: 'p' replies 0x53 ('S'). 'S' replies the seven bytes of "RTL ISP".
- R7: 'x' and 'y' reply 0x0D and issue no request.
- R8: The commands P L A c C R D d e l s reply '?' and consume no argument when the stored code is not one of 0x12, 0x13, 0x38, 0x86. Any letter outside the command set replies '?'.
- R9: 'A' takes the high address byte and then the low byte, and replies 0x0D. Later requests carry that address on seq_addr_o.
- R10: For 'R' on a word-wide target, the block issues op 5 (read high), replies its byte, then issues op 4 (read low) and replies its byte. For 'R' on target 0x86, it issues only op 4 and sends one byte. 'd' issues op 7 and replies the returned byte.
- R11: With target 0x86, 'C' consumes its data byte, replies '?' and issues no request.
- R12: Operation codes are: P→0, L→1, c→2, C→3, D→6, e→8, l→9. For c, C, D and l the argument byte is on seq_data_o. The 0x0D reply is sent only after that request's done.
- R13: While tx_valid_o is high and tx_ready_i is low, tx_valid_o and tx_data_o hold. A request holds seq_req_o, seq_op_o and seq_addr_o until seq_done_i, and any reply byte waits for the preceding done.
- R14: 's' on a word-wide target issues op 10 three times, with seq_addr_o equal to 2, then 1, then 0, and replies each returned byte after its request. On target 0x86 it replies '?' with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 8 | Received host byte |
| rx_valid_i | input | 1 | Received byte valid |
| rx_ready_o | output | 1 | Interpreter accepts a byte |
| tx_data_o | output | 8 | Reply byte |
| tx_valid_o | output | 1 | Reply byte valid |
| tx_ready_i | input | 1 | Transmit side accepts the byte |
| seq_req_o | output | 1 | Sequencer request, held until done |
| seq_op_o | output | 4 | Operation code |
| seq_addr_o | output | 16 | Address of the operation |
| seq_data_o | output | 8 | Write or lock data byte |
| seq_dev_o | output | 8 | Stored target code |
| seq_done_i | input | 1 | Sequencer finished the request |
| seq_rdata_i | input | 8 | Byte returned by a read, valid with done |

## Verification
A wrong stored target code shows up on the very next gated command. The reply changes between '?' and a real reply, and the count of read-back bytes for 'R' changes. A corrupted address register shows on seq_addr_o at the next request. A slipped step counter shows within one command as a missing, repeated or reordered reply byte. Each reply byte is tagged with the number of completed requests at the moment it was sent, so a reply that overtakes its done is visible at once.

// File: rtl/prog_cmd_pkg.sv
package prog_cmd_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 16;
  localparam int N_DEV  = 4;
  // supported target codes, listed in reply order, first in the low byte
  localparam logic [N_DEV*BYTE_W-1:0] DEV_LIST = {8'h86, 8'h38, 8'h13, 8'h12};
  localparam logic [BYTE_W-1:0] WIDE1_CODE = 8'h86;  // byte-wide program memory

  localparam logic [7:0] CH_CR  = 8'h0D;
  localparam logic [7:0] CH_ERR = 8'h3F;
  localparam logic [7:0] CH_ESC = 8'h1B;
  localparam logic [7:0] CH_NUL = 8'h00;  // pseudo command: refused

  typedef enum logic [3:0] {
    OP_ENTER = 4'd0,
    OP_LEAVE = 4'd1,
    OP_WR_LO = 4'd2,
    OP_WR_HI = 4'd3,
    OP_RD_LO = 4'd4,
    OP_RD_HI = 4'd5,
    OP_WR_EE = 4'd6,
    OP_RD_EE = 4'd7,
    OP_ERASE = 4'd8,
    OP_LOCK  = 4'd9,
    OP_SIG   = 4'd10
  } seq_op_e;

  typedef enum logic [1:0] {ACT_RX, ACT_SEQ, ACT_TX, ACT_END} act_e;
  typedef enum logic [1:0] {ARG_DEV, ARG_AH, ARG_AL, ARG_DAT} arg_e;

  typedef struct packed {
    act_e        act;
    arg_e        arg;
    seq_op_e     op;
    logic [1:0]  sig_idx;
    logic        tx_rd;
    logic [7:0]  tx_byte;
  } step_t;

endpackage

// File: rtl/prog_dev_check.sv
module prog_dev_check
  import prog_cmd_pkg::*;
#(
  parameter int                         NUM   = N_DEV,
  parameter logic [NUM*BYTE_W-1:0]      LIST  = DEV_LIST,
  parameter logic [BYTE_W-1:0]          WIDE1 = WIDE1_CODE
) (
  input  logic [BYTE_W-1:0] dev_i,
  output logic              ok_o,
  output logic              byte_wide_o
);

  logic [NUM-1:0] hit;

  for (genvar i = 0; i < NUM; i++) begin : g_hit
    assign hit[i] = (dev_i == LIST[i*BYTE_W +: BYTE_W]);
  end

  assign ok_o        = |hit;
  assign byte_wide_o = (dev_i == WIDE1);

endmodule

// File: rtl/prog_cmd_plan.sv
module prog_cmd_plan
  import prog_cmd_pkg::*;
#(
  parameter int          STEP_W = 4,
  parameter int          SW_MAJ = 1,
  parameter int          SW_MIN = 5,
  parameter int          HW_MAJ = 1,
  parameter int          HW_MIN = 0,
  parameter logic [55:0] ID_STR = "RTL ISP"
) (
  input  logic [7:0]        cmd_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              byte_wide_i,
  output step_t             st_o
);

  localparam int ID_LEN = 7;

  function automatic step_t f_end();
    return '{act: ACT_END, arg: ARG_DEV, op: OP_ENTER, sig_idx: 2'd0,
             tx_rd: 1'b0, tx_byte: 8'h00};
  endfunction

  function automatic step_t f_tx(input logic [7:0] b);
    step_t s = f_end();
    s.act = ACT_TX;
    s.tx_byte = b;
    return s;
  endfunction

  function automatic step_t f_rd();
    step_t s = f_end();
    s.act = ACT_TX;
    s.tx_rd = 1'b1;
    return s;
  endfunction

  function automatic step_t f_rx(input arg_e a);
    step_t s = f_end();
    s.act = ACT_RX;
    s.arg = a;
    return s;
  endfunction

  function automatic step_t f_seq(input seq_op_e op, input logic [1:0] idx);
    step_t s = f_end();
    s.act = ACT_SEQ;
    s.op = op;
    s.sig_idx = idx;
    return s;
  endfunction

  // rx arg, request, acknowledge
  function automatic step_t f_wr(input int n, input seq_op_e op);
    case (n)
      0:       return f_rx(ARG_DAT);
      1:       return f_seq(op, 2'd0);
      2:       return f_tx(CH_CR);
      default: return f_end();
    endcase
  endfunction

  // request, acknowledge
  function automatic step_t f_op(input int n, input seq_op_e op);
    case (n)
      0:       return f_seq(op, 2'd0);
      1:       return f_tx(CH_CR);
      default: return f_end();
    endcase
  endfunction

  function automatic step_t f_ver(input int n, input int maj, input int mn);
    case (n)
      0:       return f_tx(8'(8'h30 + maj));
      1:       return f_tx(8'(8'h30 + mn));
      default: return f_end();
    endcase
  endfunction

  int n;

  always_comb begin
    n    = int'(step_i);
    st_o = f_end();
    case (cmd_i)
      "T": begin
        if (n == 0)      st_o = f_rx(ARG_DEV);
        else if (n == 1) st_o = f_tx(CH_CR);
      end
      "A": begin
        if (n == 0)      st_o = f_rx(ARG_AH);
        else if (n == 1) st_o = f_rx(ARG_AL);
        else if (n == 2) st_o = f_tx(CH_CR);
      end
      "V": st_o = f_ver(n, SW_MAJ, SW_MIN);
      "v": st_o = f_ver(n, HW_MAJ, HW_MIN);
      "t": begin
        if (n < N_DEV)       st_o = f_tx(DEV_LIST[n*BYTE_W +: BYTE_W]);
        else if (n == N_DEV) st_o = f_tx(CH_NUL);
      end
      "p": if (n == 0) st_o = f_tx("S");
      "S": if (n < ID_LEN) st_o = f_tx(ID_STR[(ID_LEN-1-n)*8 +: 8]);
      "x", "y": if (n == 0) st_o = f_tx(CH_CR);
      "P": st_o = f_op(n, OP_ENTER);
      "L": st_o = f_op(n, OP_LEAVE);
      "e": st_o = f_op(n, OP_ERASE);
      "c": st_o = f_wr(n, OP_WR_LO);
      "D": st_o = f_wr(n, OP_WR_EE);
      "l": st_o = f_wr(n, OP_LOCK);
      "C": begin
        if (!byte_wide_i)  st_o = f_wr(n, OP_WR_HI);
        else if (n == 0)   st_o = f_rx(ARG_DAT);
        else if (n == 1)   st_o = f_tx(CH_ERR);
      end
      "d": begin
        if (n == 0)      st_o = f_seq(OP_RD_EE, 2'd0);
        else if (n == 1) st_o = f_rd();
      end
      "R": begin
        if (byte_wide_i) begin
          if (n == 0)      st_o = f_seq(OP_RD_LO, 2'd0);
          else if (n == 1) st_o = f_rd();
        end else begin
          if (n == 0)      st_o = f_seq(OP_RD_HI, 2'd0);
          else if (n == 2) st_o = f_seq(OP_RD_LO, 2'd0);
          else if (n < 4)  st_o = f_rd();
        end
      end
      "s": begin
        if (byte_wide_i) begin
          if (n == 0) st_o = f_tx(CH_ERR);
        end else if (n < 6) begin
          // signature bytes fetched from index 2 down to 0
          if (n[0]) st_o = f_rd();
          else      st_o = f_seq(OP_SIG, 2'(2 - n/2));
        end
      end
      default: if (n == 0) st_o = f_tx(CH_ERR);
    endcase
  end

endmodule

// File: rtl/prog_cmd_interp.sv
module prog_cmd_interp
  import prog_cmd_pkg::*;
#(
  parameter int          STEP_W = 4,
  parameter int          SW_MAJ = 1,
  parameter int          SW_MIN = 5,
  parameter int          HW_MAJ = 1,
  parameter int          HW_MIN = 0,
  parameter logic [55:0] ID_STR = "RTL ISP"
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic              seq_req_o,
  output logic [3:0]        seq_op_o,
  output logic [ADDR_W-1:0] seq_addr_o,
  output logic [7:0]        seq_data_o,
  output logic [7:0]        seq_dev_o,
  input  logic              seq_done_i,
  input  logic [7:0]        seq_rdata_i
);

  typedef enum logic {ST_IDLE, ST_EXEC} state_e;

  state_e            state_q;
  logic [7:0]        cmd_q, dev_q, data_q, rdata_q;
  logic [ADDR_W-1:0] addr_q;
  logic [STEP_W-1:0] step_q;
  logic              dev_ok, byte_wide;
  step_t             st;

  prog_dev_check u_dev (
    .dev_i       (dev_q),
    .ok_o        (dev_ok),
    .byte_wide_o (byte_wide)
  );

  prog_cmd_plan #(
    .STEP_W (STEP_W),
    .SW_MAJ (SW_MAJ),
    .SW_MIN (SW_MIN),
    .HW_MAJ (HW_MAJ),
    .HW_MIN (HW_MIN),
    .ID_STR (ID_STR)
  ) u_plan (
    .cmd_i       (cmd_q),
    .step_i      (step_q),
    .byte_wide_i (byte_wide),
    .st_o        (st)
  );

  function automatic logic is_gated(input logic [7:0] c);
    case (c)
      "P", "L", "A", "c", "C", "R", "D", "d", "e", "l", "s": return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  wire exec = (state_q == ST_EXEC);

  assign rx_ready_o = !exec || (st.act == ACT_RX);
  assign tx_valid_o = exec && (st.act == ACT_TX);
  assign tx_data_o  = st.tx_rd ? rdata_q : st.tx_byte;
  assign seq_req_o  = exec && (st.act == ACT_SEQ);
  assign seq_op_o   = st.op;
  assign seq_addr_o = (st.op == OP_SIG) ? ADDR_W'(st.sig_idx) : addr_q;
  assign seq_data_o = data_q;
  assign seq_dev_o  = dev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cmd_q   <= CH_NUL;
      step_q  <= '0;
      dev_q   <= 8'h00;
      addr_q  <= '0;
      data_q  <= 8'h00;
      rdata_q <= 8'h00;
    end else if (!exec) begin
      if (rx_valid_i && rx_data_i != CH_ESC) begin
        cmd_q   <= (is_gated(rx_data_i) && !dev_ok) ? CH_NUL : rx_data_i;
        step_q  <= '0;
        state_q <= ST_EXEC;
      end
    end else begin
      case (st.act)
        ACT_RX: if (rx_valid_i) begin
          case (st.arg)
            ARG_DEV: dev_q <= rx_data_i;
            ARG_AH:  addr_q[ADDR_W-1:8] <= rx_data_i;
            ARG_AL:  addr_q[7:0] <= rx_data_i;
            default: data_q <= rx_data_i;
          endcase
          step_q <= step_q + 1'b1;
        end
        ACT_SEQ: if (seq_done_i) begin
          rdata_q <= seq_rdata_i;
          step_q  <= step_q + 1'b1;
        end
        ACT_TX: if (tx_ready_i) step_q <= step_q + 1'b1;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R13: reply byte held while stalled
  a_r13_tx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

  // R13: request held until done
  a_r13_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_req_o && !seq_done_i |=> seq_req_o && $stable(seq_op_o) && $stable(seq_addr_o));

  // R8: no request without a supported target
  a_r8_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_req_o |-> dev_ok);

  // R12: reply and request never overlap
  a_r12_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_valid_o && seq_req_o));

  // R2: idle accepts input and sends nothing
  a_r2_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_o |-> !tx_valid_o && !seq_req_o);

endmodule

// File: tb/prog_cmd_interp_test.sv
module prog_cmd_interp_test;

  localparam int MSK = 2047;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rx_data_i = 8'h00;
  logic        rx_valid_i = 1'b0;
  logic        rx_ready_o;
  logic [7:0]  tx_data_o;
  logic        tx_valid_o;
  logic        tx_ready_i = 1'b0;
  logic        seq_req_o;
  logic [3:0]  seq_op_o;
  logic [15:0] seq_addr_o;
  logic [7:0]  seq_data_o;
  logic [7:0]  seq_dev_o;
  logic        seq_done_i = 1'b0;
  logic [7:0]  seq_rdata_i = 8'h00;

  always #10 clk = ~clk;

  prog_cmd_interp uut (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_data_i(rx_data_i), .rx_valid_i(rx_valid_i), .rx_ready_o(rx_ready_o),
    .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i),
    .seq_req_o(seq_req_o), .seq_op_o(seq_op_o), .seq_addr_o(seq_addr_o),
    .seq_data_o(seq_data_o), .seq_dev_o(seq_dev_o),
    .seq_done_i(seq_done_i), .seq_rdata_i(seq_rdata_i)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  bit ready_rand = 0;

  // observed traffic
  logic [7:0]  rbuf [0:MSK];
  int          rseq [0:MSK];
  int          rn = 0;
  logic [3:0]  sop  [0:MSK];
  logic [15:0] saddr[0:MSK];
  logic [7:0]  sdata[0:MSK];
  int          sn = 0;
  int          hold_bad = 0;

  // expected traffic for one command
  logic [7:0]  ebuf [0:15];
  int          eseq [0:15];
  int          en;
  logic [3:0]  eop  [0:7];
  logic [15:0] eaddr[0:7];
  logic [7:0]  edata[0:7];
  bit          echk [0:7];
  int          eopn;

  logic [7:0]  dev_m = 8'h00;
  logic [15:0] addr_m = 16'h0000;

  function automatic logic [7:0] rd_model(input logic [3:0] op, input logic [15:0] a);
    return {op, 4'h0} ^ a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic bit dev_sup(input logic [7:0] d);
    return d == 8'h12 || d == 8'h13 || d == 8'h38 || d == 8'h86;
  endfunction

  function automatic bit gated(input logic [7:0] c);
    case (c)
      "P", "L", "A", "c", "C", "R", "D", "d", "e", "l", "s": return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input logic [7:0] c, input bit sup, input bit bw);
    if (c == 8'h1B) return "R2";
    if (gated(c) && !sup) return "R8";
    case (c)
      "T": return "R3";
      "V", "v": return "R4";
      "t": return "R5";
      "p", "S": return "R6";
      "x", "y": return "R7";
      "A": return "R9";
      "R", "d": return "R10";
      "C": return bw ? "R11" : "R12";
      "s": return "R14";
      "P", "L", "c", "D", "e", "l": return "R12";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input int got, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", rq, what, got, exp);
    end
  endtask

  task automatic push_rep(input logic [7:0] b);
    ebuf[en] = b;
    eseq[en] = eopn;
    en++;
  endtask

  task automatic push_op(input logic [3:0] op, input logic [15:0] a,
                         input logic [7:0] d, input bit chk);
    eop[eopn] = op; eaddr[eopn] = a; edata[eopn] = d; echk[eopn] = chk;
    eopn++;
  endtask

  task automatic push_rd(input logic [3:0] op, input logic [15:0] a);
    push_op(op, a, 8'h00, 1'b0);
    push_rep(rd_model(op, a));
  endtask

  // called at a falling edge
  task automatic send_byte(input logic [7:0] b);
    rx_data_i  = b;
    rx_valid_i = 1'b1;
    while (!rx_ready_o) @(negedge clk);
    @(negedge clk);
    rx_valid_i = 1'b0;
  endtask

  // transmit side and stall check
  bit         prev_stall = 0;
  logic [7:0] prev_data = 8'h00;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall && !(tx_valid_o && tx_data_o == prev_data)) hold_bad++;
      tx_ready_i = ready_rand ? ($urandom % 4 != 0) : 1'b1;
      if (tx_valid_o && tx_ready_i) begin
        rbuf[rn & MSK] = tx_data_o;
        rseq[rn & MSK] = sn;
        rn++;
      end
      prev_stall = tx_valid_o && !tx_ready_i;
      prev_data  = tx_data_o;
    end
  end

  // sequencer model
  int         scnt = 1;
  bit         pend = 0;
  logic [3:0] pend_op = 4'h0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend && !(seq_req_o && seq_op_o == pend_op)) hold_bad++;
      pend = 0;
      if (seq_done_i) begin
        seq_done_i = 1'b0;
      end else if (seq_req_o) begin
        if (scnt == 0) begin
          seq_done_i  = 1'b1;
          seq_rdata_i = rd_model(seq_op_o, seq_addr_o);
          sop[sn & MSK]   = seq_op_o;
          saddr[sn & MSK] = seq_addr_o;
          sdata[sn & MSK] = seq_data_o;
          sn++;
          scnt = $urandom % 4;
        end else begin
          scnt--;
          pend = 1;
          pend_op = seq_op_o;
        end
      end
    end
  end

  task automatic run_cmd(input logic [7:0] c, input logic [7:0] a0, input logic [7:0] a1);
    bit sup, bw;
    int nargs, rb, sb, got_r, got_s;
    string rq;
    sup = dev_sup(dev_m);
    bw  = (dev_m == 8'h86);
    rq  = req_of(c, sup, bw);
    en = 0; eopn = 0; nargs = 0;
    if (c == 8'h1B) begin
      nargs = 0;
    end else if (gated(c) && !sup) begin
      push_rep(8'h3F);
    end else begin
      case (c)
        "T": begin nargs = 1; dev_m = a0; push_rep(8'h0D); end
        "A": begin nargs = 2; addr_m = {a0, a1}; push_rep(8'h0D); end
        "V": begin push_rep(8'h31); push_rep(8'h35); end
        "v": begin push_rep(8'h31); push_rep(8'h30); end
        "t": begin
          push_rep(8'h12); push_rep(8'h13); push_rep(8'h38); push_rep(8'h86); push_rep(8'h00);
        end
        "p": push_rep(8'h53);
        "S": begin
          push_rep("R"); push_rep("T"); push_rep("L"); push_rep(" ");
          push_rep("I"); push_rep("S"); push_rep("P");
        end
        "x", "y": push_rep(8'h0D);
        "P": begin push_op(4'd0, addr_m, 8'h00, 1'b0); push_rep(8'h0D); end
        "L": begin push_op(4'd1, addr_m, 8'h00, 1'b0); push_rep(8'h0D); end
        "e": begin push_op(4'd8, addr_m, 8'h00, 1'b0); push_rep(8'h0D); end
        "c": begin nargs = 1; push_op(4'd2, addr_m, a0, 1'b1); push_rep(8'h0D); end
        "D": begin nargs = 1; push_op(4'd6, addr_m, a0, 1'b1); push_rep(8'h0D); end
        "l": begin nargs = 1; push_op(4'd9, addr_m, a0, 1'b1); push_rep(8'h0D); end
        "C": begin
          nargs = 1;
          if (bw) push_rep(8'h3F);
          else begin push_op(4'd3, addr_m, a0, 1'b1); push_rep(8'h0D); end
        end
        "d": push_rd(4'd7, addr_m);
        "R": begin
          if (!bw) push_rd(4'd5, addr_m);
          push_rd(4'd4, addr_m);
        end
        "s": begin
          if (bw) push_rep(8'h3F);
          else begin push_rd(4'd10, 16'd2); push_rd(4'd10, 16'd1); push_rd(4'd10, 16'd0); end
        end
        default: push_rep(8'h3F);
      endcase
    end
    rb = rn; sb = sn;
    send_byte(c);
    if (nargs >= 1) send_byte(a0);
    if (nargs >= 2) send_byte(a1);
    for (int k = 0; k < 400; k++) begin
      if (rn - rb >= en && sn - sb >= eopn) break;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    got_r = rn - rb;
    got_s = sn - sb;
    check(got_r == en, rq, $sformatf("reply count cmd %h", c), got_r, en);
    for (int i = 0; i < en && i < got_r; i++) begin
      check(rbuf[(rb+i) & MSK] == ebuf[i], rq, $sformatf("reply %0d cmd %h", i, c),
            rbuf[(rb+i) & MSK], ebuf[i]);
      // R13/R12: reply waits for preceding done
      check(rseq[(rb+i) & MSK] - sb == eseq[i], rq, $sformatf("reply %0d order cmd %h", i, c),
            rseq[(rb+i) & MSK] - sb, eseq[i]);
    end
    check(got_s == eopn, rq, $sformatf("request count cmd %h", c), got_s, eopn);
    for (int i = 0; i < eopn && i < got_s; i++) begin
      check(sop[(sb+i) & MSK] == eop[i], rq, $sformatf("op %0d cmd %h", i, c),
            sop[(sb+i) & MSK], eop[i]);
      check(saddr[(sb+i) & MSK] == eaddr[i], rq, $sformatf("addr %0d cmd %h", i, c),
            saddr[(sb+i) & MSK], eaddr[i]);
      if (echk[i])
        check(sdata[(sb+i) & MSK] == edata[i], rq, $sformatf("data %0d cmd %h", i, c),
              sdata[(sb+i) & MSK], edata[i]);
    end
  endtask

  localparam string LETTERS = "TTTAVvtpSxyPLcCRDdeslZq?";

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(rx_ready_o == 1'b1, "R1", "rx_ready", rx_ready_o, 1);
    check(tx_valid_o == 1'b0, "R1", "tx_valid", tx_valid_o, 0);
    check(seq_req_o == 1'b0, "R1", "seq_req", seq_req_o, 0);
    check(seq_dev_o == 8'h00, "R1", "target code", seq_dev_o, 0);

    // directed corner cases
    run_cmd("R", 8'h00, 8'h00);   // R8 refused before selection
    run_cmd("c", 8'h00, 8'h00);   // R8 no argument consumed
    run_cmd(8'h1B, 8'h00, 8'h00); // R2
    run_cmd("V", 8'h00, 8'h00);   // R4 decoded after ESC
    run_cmd("v", 8'h00, 8'h00);
    run_cmd("t", 8'h00, 8'h00);   // R5
    run_cmd("p", 8'h00, 8'h00);   // R6
    run_cmd("S", 8'h00, 8'h00);
    run_cmd("x", 8'h00, 8'h00);   // R7
    run_cmd("y", 8'h00, 8'h00);
    run_cmd("Q", 8'h00, 8'h00);   // R8 unknown
    run_cmd("T", 8'h12, 8'h00);   // R3
    check(seq_dev_o == 8'h12, "R3", "stored code", seq_dev_o, 8'h12);
    run_cmd("A", 8'h12, 8'h34);   // R9
    run_cmd("R", 8'h00, 8'h00);   // R10 word-wide
    run_cmd("d", 8'h00, 8'h00);
    run_cmd("C", 8'h5C, 8'h00);   // R12
    run_cmd("s", 8'h00, 8'h00);   // R14
    run_cmd("T", 8'h86, 8'h00);
    run_cmd("R", 8'h00, 8'h00);   // R10 byte-wide
    run_cmd("C", 8'h77, 8'h00);   // R11
    run_cmd("s", 8'h00, 8'h00);   // R14 refused
    run_cmd("T", 8'h55, 8'h00);   // R3 unsupported code still stored
    run_cmd("e", 8'h00, 8'h00);   // R8

    // random phase with transmit stalls
    ready_rand = 1;
    for (int it = 0; it < 160; it++) begin
      logic [7:0] c, a0, a1;
      int r;
      r  = $urandom % (LETTERS.len() + 2);
      c  = (r < LETTERS.len()) ? LETTERS[r] : 8'h1B;
      a0 = 8'($urandom);
      a1 = 8'($urandom);
      if (c == "T") begin
        case ($urandom % 6)
          0: a0 = 8'h12; 1: a0 = 8'h13; 2: a0 = 8'h38;
          3: a0 = 8'h86; 4: a0 = 8'h86; default: a0 = a0;
        endcase
      end
      run_cmd(c, a0, a1);
    end

    check(hold_bad == 0, "R13", "hold violations", hold_bad, 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule